// File: doc/BRIEF.md
# Memory ordering and fence controller

This block sits between an in-order issue stage and the memory port of a single processor. Each cycle the issue stage presents at most one memory operation together with a kind code. The block answers in the same cycle with a grant when the ordering rules allow the operation to go out. When they do not, the operation waits at the head of the issue stage and is presented again. The block counts loads that have not yet returned data and stores that have not yet been posted or acknowledged. It also tracks whether a synchronizing operation is still in flight, and whether that operation has acquire meaning. Completion arrives as single-cycle pulses: one for read data, one for write acknowledgement, and one for synchronizing operations.

A mode input selects between two rule sets. In weak-ordering mode, every synchronizing operation acts as a two-way barrier. In release-consistency mode, acquire and release each order only one direction. A fence waits for every older access in either mode. When a fence or an acquire is granted, the block raises a one-cycle flush request so that younger instructions fetched early are executed again.

Top module: `mem_order_ctrl`

## Requirements
- R1: After reset, both outstanding counts read 0 and the sync-busy flag is low.
- R2: `op_grant_o` is high only while `op_valid_i` is high and the rules below permit issue. A granted load (kind 0) raises the read count by one. A granted store (kind 1) raises the write count by one. Each `rd_done_i` or `wr_ack_i` pulse lowers the matching count by one.
- R3: Each count saturates at 15. A load is refused while the read count is 15, and a store is refused while the write count is 15, even in a cycle that also carries a completion pulse. A completion pulse that arrives while its count is 0 leaves the count at 0.
- R4: A fence (kind 5) is refused until both counts are 0 and no synchronizing operation is in flight. In its grant cycle, `flush_o` is high. `flush_o` is low in the following cycle.
- R5: Weak-ordering mode (`mode_i` = 0): a load or store is refused while any synchronizing operation is in flight.
- R6: Weak-ordering mode: a synchronizing operation (kinds 2 sync, 3 acquire, 4 release, 6 or 7 atomic) is refused while the write count is nonzero or another synchronizing operation is in flight. Older reads do not hold it back. When granted, it sets the sync-busy flag.
- R7: Release mode (`mode_i` = 1): a load or store is refused while an acquire-class operation (sync, acquire or atomic) is in flight. An in-flight release does not hold back loads or stores.
- R8: Release mode: a release is refused until both counts are 0 and no synchronizing operation is in flight.
- R9: Release mode: an acquire waits only for an earlier synchronizing operation to complete. It does not wait for outstanding reads or writes. `flush_o` is high in the acquire's grant cycle in either mode.
- R10: Release mode: a sync or atomic operation waits like a release, and while it is in flight it holds back loads and stores like an acquire.
- R11: A `sync_done_i` pulse clears the sync-busy flag. A pulse while the flag is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = weak ordering, 1 = release consistency |
| op_valid_i | input | 1 | An operation is presented |
| op_kind_i | input | 3 | 0 load, 1 store, 2 sync, 3 acquire, 4 release, 5 fence, 6/7 atomic |
| rd_done_i | input | 1 | One outstanding read returned data |
| wr_ack_i | input | 1 | One outstanding write posted or acknowledged |
| sync_done_i | input | 1 | The in-flight synchronizing operation performed |
| op_grant_o | output | 1 | The presented operation issues this cycle |
| flush_o | output | 1 | One-cycle pipeline flush request |
| rd_cnt_o | output | 4 | Outstanding read count |
| wr_cnt_o | output | 4 | Outstanding write count |
| sync_busy_o | output | 1 | A synchronizing operation is in flight |

## Verification
The checker tests some rules on every cycle. It confirms that no grant appears without a valid operation, and that no load or store is granted into a full counter. It checks that a fence or release is granted only with empty counts. It checks that weak mode never grants an ordinary access while a synchronizing operation is in flight, and that the read count tracks a granted load. The bench scenarios are needed for everything that depends on a sequence of events. These include stalls that lift only after the last completion pulse, the contrast between an acquire that proceeds past pending writes and a release that does not, release mode letting ordinary accesses overtake an in-flight release, and stray completion pulses that leave state unchanged.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SYNC  = 3'd2,
        OP_ACQ   = 3'd3,
        OP_REL   = 3'd4,
        OP_FENCE = 3'd5,
        OP_ATOM  = 3'd6,
        OP_ATOMX = 3'd7
    } op_kind_e;

    typedef enum logic {
        MODE_WEAK    = 1'b0,
        MODE_RELEASE = 1'b1
    } order_mode_e;

    // in-flight synchronizing operation
    typedef struct packed {
        logic pend;
        logic acq;
    } sync_st_t;

    function automatic logic is_sync_class(op_kind_e k);
        return (k == OP_SYNC) || (k == OP_ACQ) || (k == OP_REL) ||
               (k == OP_ATOM) || (k == OP_ATOMX);
    endfunction

endpackage

// File: rtl/mo_sat_counter.sv
module mo_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        // a pulse at zero is dropped; the increment is gated by full upstream
        if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_d - 1'b1;
        end
        if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_d + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign full_o  = (cnt_q == CNT_MAX);
    assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/mo_issue_rules.sv
module mo_issue_rules
    import mo_pkg::*;
(
    input  logic     mode_i,
    input  logic     valid_i,
    input  op_kind_e kind_i,
    input  logic     rd_empty_i,
    input  logic     wr_empty_i,
    input  logic     rd_full_i,
    input  logic     wr_full_i,
    input  sync_st_t sync_i,
    output logic     grant_o,
    output logic     flush_o,
    output logic     take_load_o,
    output logic     take_store_o,
    output logic     take_sync_o,
    output logic     sync_acq_o
);
    logic all_drained;
    logic ordinary_hold;
    logic hold;

    always_comb begin
        all_drained = rd_empty_i && wr_empty_i && !sync_i.pend;

        if (order_mode_e'(mode_i) == MODE_RELEASE) begin
            ordinary_hold = sync_i.pend && sync_i.acq;
        end else begin
            ordinary_hold = sync_i.pend;
        end

        hold = 1'b1;
        unique case (kind_i)
            OP_LOAD:  hold = ordinary_hold || rd_full_i;
            OP_STORE: hold = ordinary_hold || wr_full_i;
            OP_FENCE: hold = !all_drained;
            OP_ACQ: begin
                if (order_mode_e'(mode_i) == MODE_RELEASE) begin
                    hold = sync_i.pend;
                end else begin
                    hold = sync_i.pend || !wr_empty_i;
                end
            end
            OP_SYNC, OP_REL, OP_ATOM, OP_ATOMX: begin
                if (order_mode_e'(mode_i) == MODE_RELEASE) begin
                    hold = !all_drained;
                end else begin
                    hold = sync_i.pend || !wr_empty_i;
                end
            end
            default: hold = 1'b1;
        endcase

        grant_o      = valid_i && !hold;
        flush_o      = grant_o && ((kind_i == OP_FENCE) || (kind_i == OP_ACQ));
        take_load_o  = grant_o && (kind_i == OP_LOAD);
        take_store_o = grant_o && (kind_i == OP_STORE);
        take_sync_o  = grant_o && is_sync_class(kind_i);
        sync_acq_o   = (kind_i != OP_REL);
    end

endmodule

// File: rtl/mem_order_ctrl.sv
module mem_order_ctrl
    import mo_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             op_valid_i,
    input  logic [2:0]       op_kind_i,
    input  logic             rd_done_i,
    input  logic             wr_ack_i,
    input  logic             sync_done_i,
    output logic             op_grant_o,
    output logic             flush_o,
    output logic [CNT_W-1:0] rd_cnt_o,
    output logic [CNT_W-1:0] wr_cnt_o,
    output logic             sync_busy_o
);
    localparam int N_CH  = 2;
    localparam int CH_RD = 0;
    localparam int CH_WR = 1;

    sync_st_t sync_d, sync_q;

    logic             take_load, take_store, take_sync, sync_acq;
    logic [N_CH-1:0]  ch_inc, ch_dec, ch_full, ch_empty;
    logic [CNT_W-1:0] ch_cnt [N_CH];

    assign ch_inc[CH_RD] = take_load;
    assign ch_inc[CH_WR] = take_store;
    assign ch_dec[CH_RD] = rd_done_i;
    assign ch_dec[CH_WR] = wr_ack_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_track
        mo_sat_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (ch_inc[g]),
            .dec_i   (ch_dec[g]),
            .cnt_o   (ch_cnt[g]),
            .full_o  (ch_full[g]),
            .empty_o (ch_empty[g])
        );
    end

    mo_issue_rules rules_i (
        .mode_i       (mode_i),
        .valid_i      (op_valid_i),
        .kind_i       (op_kind_e'(op_kind_i)),
        .rd_empty_i   (ch_empty[CH_RD]),
        .wr_empty_i   (ch_empty[CH_WR]),
        .rd_full_i    (ch_full[CH_RD]),
        .wr_full_i    (ch_full[CH_WR]),
        .sync_i       (sync_q),
        .grant_o      (op_grant_o),
        .flush_o      (flush_o),
        .take_load_o  (take_load),
        .take_store_o (take_store),
        .take_sync_o  (take_sync),
        .sync_acq_o   (sync_acq)
    );

    always_comb begin
        sync_d = sync_q;
        if (sync_done_i) begin
            sync_d.pend = 1'b0;
            sync_d.acq  = 1'b0;
        end
        // a new sync-class grant is only possible while none is pending
        if (take_sync) begin
            sync_d.pend = 1'b1;
            sync_d.acq  = sync_acq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rd_cnt_o    = ch_cnt[CH_RD];
    assign wr_cnt_o    = ch_cnt[CH_WR];
    assign sync_busy_o = sync_q.pend;

endmodule

// File: rtl/mo_order_chk.sv
module mo_order_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic             op_valid_i,
    input logic [2:0]       op_kind_i,
    input logic             rd_done_i,
    input logic             wr_ack_i,
    input logic             sync_done_i,
    input logic             op_grant_o,
    input logic             flush_o,
    input logic [CNT_W-1:0] rd_cnt_o,
    input logic [CNT_W-1:0] wr_cnt_o,
    input logic             sync_busy_o
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    // R2
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_grant_o |-> op_valid_i);

    // R2
    load_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_grant_o && op_kind_i == 3'd0 && !rd_done_i))
        |-> rd_cnt_o == CNT_W'($past(rd_cnt_o) + 1'b1));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_grant_o && ((op_kind_i == 3'd0 && rd_cnt_o == FULL) ||
                         (op_kind_i == 3'd1 && wr_cnt_o == FULL))));

    // R4
    fence_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_grant_o && op_kind_i == 3'd5)
        |-> (rd_cnt_o == '0 && wr_cnt_o == '0 && !sync_busy_o));

    // R4
    flush_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (op_grant_o && (op_kind_i == 3'd5 || op_kind_i == 3'd3)));

    // R5
    weak_ordinary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && sync_busy_o && op_kind_i <= 3'd1) |-> !op_grant_o);

    // R8
    release_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && op_grant_o && op_kind_i == 3'd4)
        |-> (rd_cnt_o == '0 && wr_cnt_o == '0 && !sync_busy_o));

    // R11
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sync_done_i)) |-> !sync_busy_o);

endmodule

bind mem_order_ctrl mo_order_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .op_valid_i  (op_valid_i),
    .op_kind_i   (op_kind_i),
    .rd_done_i   (rd_done_i),
    .wr_ack_i    (wr_ack_i),
    .sync_done_i (sync_done_i),
    .op_grant_o  (op_grant_o),
    .flush_o     (flush_o),
    .rd_cnt_o    (rd_cnt_o),
    .wr_cnt_o    (wr_cnt_o),
    .sync_busy_o (sync_busy_o)
);

// File: tb/mem_order_ctrl_tb_top.sv
module mem_order_ctrl_tb_top;

    localparam logic [2:0] LD = 3'd0, ST = 3'd1, SY = 3'd2, AQ = 3'd3,
                           RL = 3'd4, FN = 3'd5, AT = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       valid = 1'b0;
    logic [2:0] kind = 3'd0;
    logic       rd_done = 1'b0, wr_ack = 1'b0, sync_done = 1'b0;
    logic       grant, flush, busy;
    logic [3:0] rd_cnt, wr_cnt;

    always #2 clk = ~clk;

    mem_order_ctrl #(.CNT_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .op_valid_i(valid),
        .op_kind_i(kind), .rd_done_i(rd_done), .wr_ack_i(wr_ack),
        .sync_done_i(sync_done), .op_grant_o(grant), .flush_o(flush),
        .rd_cnt_o(rd_cnt), .wr_cnt_o(wr_cnt), .sync_busy_o(busy)
    );

    typedef struct {
        logic  g;
        logic  f;
        int    rd;
        int    wr;
        logic  b;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    int   m_rd = 0, m_wr = 0;
    logic m_busy = 1'b0;

    function automatic void cmp(string tag, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endfunction

    // monitor: pops expectations and compares against live outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "grant", int'(grant), int'(e.g));
                cmp(e.tag, "flush", int'(flush), int'(e.f));
                cmp(e.tag, "rd_cnt", int'(rd_cnt), e.rd);
                cmp(e.tag, "wr_cnt", int'(wr_cnt), e.wr);
                cmp(e.tag, "sync_busy", int'(busy), int'(e.b));
            end
        end
    end

    // driver: one cycle of stimulus plus the expected response
    task automatic cyc(input logic v, input logic [2:0] k, input logic rdd,
                       input logic wra, input logic sd, input logic eg,
                       input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        valid = v; kind = k; rd_done = rdd; wr_ack = wra; sync_done = sd;
        #1;
        e.g = eg; e.f = ef; e.rd = m_rd; e.wr = m_wr; e.b = m_busy; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        if (rdd && m_rd != 0) m_rd--;
        if (wra && m_wr != 0) m_wr--;
        if (sd) m_busy = 1'b0;
        if (eg && k == LD) m_rd++;
        if (eg && k == ST) m_wr++;
        if (eg && (k == SY || k == AQ || k == RL || k >= AT)) m_busy = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc(0, LD, 0, 0, 0, 0, 0, "R1");
        // R2 counting, R4 fence drain and flush (weak mode)
        cyc(1, LD, 0, 0, 0, 1, 0, "R2");
        cyc(1, ST, 0, 0, 0, 1, 0, "R2");
        cyc(1, FN, 0, 0, 0, 0, 0, "R4");
        cyc(1, FN, 1, 0, 0, 0, 0, "R4");
        cyc(1, FN, 0, 1, 0, 0, 0, "R4");
        cyc(1, FN, 0, 0, 0, 1, 1, "R4");
        cyc(0, FN, 0, 0, 0, 0, 0, "R4");
        // R6 sync waits for writes, R5 ordinary waits for sync
        cyc(1, ST, 0, 0, 0, 1, 0, "R2");
        cyc(1, SY, 0, 0, 0, 0, 0, "R6");
        cyc(1, SY, 0, 1, 0, 0, 0, "R6");
        cyc(1, SY, 0, 0, 0, 1, 0, "R6");
        cyc(1, LD, 0, 0, 0, 0, 0, "R5");
        cyc(1, LD, 0, 0, 1, 0, 0, "R5");
        cyc(1, LD, 0, 0, 0, 1, 0, "R5");
        // R6 weak acquire ignores older reads; R9 flush on acquire
        cyc(1, AQ, 0, 0, 0, 1, 1, "R9");
        cyc(1, ST, 0, 0, 0, 0, 0, "R5");
        cyc(0, LD, 0, 0, 1, 0, 0, "R11");
        cyc(0, LD, 1, 0, 0, 0, 0, "R2");
        // R11 and R3 stray pulses
        cyc(0, LD, 1, 1, 1, 0, 0, "R11");
        cyc(0, LD, 0, 0, 0, 0, 0, "R3");
        // R3 saturation
        for (int i = 0; i < 15; i++) cyc(1, LD, 0, 0, 0, 1, 0, "R3");
        cyc(1, LD, 0, 0, 0, 0, 0, "R3");
        cyc(1, LD, 1, 0, 0, 0, 0, "R3");
        cyc(1, LD, 0, 0, 0, 1, 0, "R3");
        for (int i = 0; i < 15; i++) cyc(0, LD, 1, 0, 0, 0, 0, "R3");
        cyc(0, LD, 0, 0, 0, 0, 0, "R3");

        // release mode
        @(negedge clk);
        mode = 1'b1;
        cyc(1, ST, 0, 0, 0, 1, 0, "R2");
        cyc(1, AQ, 0, 0, 0, 1, 1, "R9");
        cyc(1, LD, 0, 0, 0, 0, 0, "R7");
        cyc(1, LD, 0, 0, 1, 0, 0, "R7");
        cyc(1, LD, 0, 0, 0, 1, 0, "R7");
        cyc(1, RL, 0, 0, 0, 0, 0, "R8");
        cyc(1, RL, 1, 0, 0, 0, 0, "R8");
        cyc(1, RL, 0, 1, 0, 0, 0, "R8");
        cyc(1, RL, 0, 0, 0, 1, 0, "R8");
        cyc(1, LD, 0, 0, 0, 1, 0, "R7");
        cyc(1, ST, 0, 0, 0, 1, 0, "R7");
        cyc(1, AQ, 0, 0, 0, 0, 0, "R9");
        cyc(1, AQ, 0, 0, 1, 0, 0, "R9");
        cyc(1, AQ, 0, 0, 0, 1, 1, "R9");
        cyc(0, AT, 0, 0, 1, 0, 0, "R11");
        cyc(1, AT, 0, 0, 0, 0, 0, "R10");
        cyc(1, AT, 1, 1, 0, 0, 0, "R10");
        cyc(1, AT, 0, 0, 0, 1, 0, "R10");
        cyc(1, ST, 0, 0, 0, 0, 0, "R10");
        cyc(1, ST, 0, 0, 1, 0, 0, "R10");
        cyc(1, ST, 0, 0, 0, 1, 0, "R10");
        cyc(0, LD, 0, 1, 0, 0, 0, "R2");
        cyc(0, LD, 0, 0, 0, 0, 0, "R1");

        @(negedge clk);
        valid = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule